// File: doc/BRIEF.md
# Gate Underlap and Narrow-Pulse Filter

This block sits between a three-phase PWM modulator and the gate drivers of a three-leg inverter. For each phase it takes one raw PWM level and produces a top-switch and a bottom-switch drive. Each raw level first passes through a filter that discards any high or low interval shorter than a programmed minimum width. The filtered level then drives the complementary outputs. Whenever the filtered level changes, the output that is turning off drops straight away. The output that is turning on waits for a programmed dead interval, so both switches of one leg are never conducting together.

Both times are counted in units of an input `tick`, which the carrier logic supplies once per time unit. Both times are also set by inverted codes: the dead interval is `63 - dly_code` ticks and the minimum width is `127 - del_code` ticks. A larger code therefore gives a shorter time, and the top code of each field switches that feature off.

Top module: `pwm_gate_shaper`

## Requirements
- R1: With `del_code` = 127 and `dly_code` = 63, each `gate_top[i]` equals `pwm_in[i]` and each `gate_bot[i]` equals its inverse, one clock after the input changes.
- R2: After the filtered level of a phase changes, the output being switched on rises only once `63 - dly_code` further ticks have been counted, with `tick` held high. With `tick` high on every cycle, a high interval of W cycles gives W − D cycles of top drive, where D = 63 − dly_code, or none at all when W ≤ D.
- R3: The output being switched off falls on the same clock edge that the filtered level changes. The bottom drive of a pulse that passes the filter is therefore low for W + D cycles in total.
- R4: `gate_top[i]` and `gate_bot[i]` are never both high in the same cycle.
- R5: A high interval of the raw input lasting fewer than M = 127 − del_code ticks is discarded and produces no top drive. An interval of exactly M ticks is kept, with its length unchanged.
- R6: Low intervals are filtered independently, by the same rule: a short low gap in a high input produces no bottom drive.
- R7: When a time is programmed as non-zero, an output edge that depends on that time happens only on a clock edge where `tick` is high.
- R8: While `rst_n` is low, all six outputs are low. After release, with the raw inputs low, every bottom output rises once the dead interval has been counted.
- R9: The three phases are independent: stimulus on one phase leaves the outputs of the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-unit strobe from the carrier logic |
| pwm_in | input | 3 | Raw PWM level for each phase |
| dly_code | input | 6 | Inverted dead-time code (dead = 63 − code ticks) |
| del_code | input | 7 | Inverted minimum-width code (width = 127 − code ticks) |
| gate_top | output | 3 | Top-switch drive for each phase |
| gate_bot | output | 3 | Bottom-switch drive for each phase |

## Verification
Some properties are checked on every cycle. These are that the two outputs of a leg are never high together, that reset clears the outputs, and that any output edge whose timing depends on a programmed code falls on a tick edge. Only the bench's scenarios show the lengths themselves. It counts how many cycles each output stays high across single pulses and gaps, at the deletion boundary, with dead times longer than the pulse, and with the tick running slower than the clock. These counts confirm that the dead time and the minimum width come out as the inverted codes say, and that the other phases stay untouched.

// File: rtl/pwm_gate_shaper.sv
module pwm_gate_shaper #(
  parameter int NPH   = 3,
  parameter int DLY_W = 6,
  parameter int DEL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NPH-1:0]   pwm_in,
  input  logic [DLY_W-1:0] dly_code,
  input  logic [DEL_W-1:0] del_code,
  output logic [NPH-1:0]   gate_top,
  output logic [NPH-1:0]   gate_bot
);
  localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};
  localparam logic [DEL_W-1:0] DEL_MAX = {DEL_W{1'b1}};

  logic [DLY_W-1:0] dead_len;
  logic [DEL_W-1:0] min_len;

  assign dead_len = DLY_MAX - dly_code;
  assign min_len  = DEL_MAX - del_code;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic             filt, rdy;
    logic [DEL_W-1:0] wcnt;
    logic [DLY_W-1:0] dcnt;
    logic             differ, flip, dead_done;

    assign differ    = pwm_in[g] != filt;
    assign flip      = differ && (min_len == '0 ||
                       (tick && ({1'b0, wcnt} + 1'b1 >= {1'b0, min_len})));
    assign dead_done = dead_len == '0 ||
                       (tick && ({1'b0, dcnt} + 1'b1 >= {1'b0, dead_len}));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filt <= 1'b0;
        wcnt <= '0;
      end else if (flip) begin
        filt <= ~filt;
        wcnt <= '0;
      end else if (!differ) begin
        wcnt <= '0;
      end else if (tick) begin
        wcnt <= wcnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy  <= 1'b0;
        dcnt <= '0;
      end else if (flip) begin
        rdy  <= dead_len == '0;
        dcnt <= '0;
      end else if (!rdy) begin
        if (dead_done) rdy <= 1'b1;
        else if (tick) dcnt <= dcnt + 1'b1;
      end
    end

    assign gate_top[g] = filt & rdy;
    assign gate_bot[g] = ~filt & rdy;
  end
endmodule

// File: rtl/pwm_gate_shaper_chk.sv
module pwm_gate_shaper_chk #(
  parameter int NPH   = 3,
  parameter int DLY_W = 6,
  parameter int DEL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [NPH-1:0]   pwm_in,
  input logic [DLY_W-1:0] dly_code,
  input logic [DEL_W-1:0] del_code,
  input logic [NPH-1:0]   gate_top,
  input logic [NPH-1:0]   gate_bot
);
  localparam logic [DLY_W-1:0] DLY_OFF = {DLY_W{1'b1}};
  localparam logic [DEL_W-1:0] DEL_OFF = {DEL_W{1'b1}};

  always @(posedge clk)
    if (!rst_n)
      assert_reset_low_R8: assert (gate_top == '0 && gate_bot == '0);

  for (genvar g = 0; g < NPH; g++) begin : g_chk
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_top[g] && gate_bot[g]));

    assert_top_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_top[g]) && $past(dly_code) != DLY_OFF) |-> $past(tick));

    assert_bot_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_bot[g]) && $past(dly_code) != DLY_OFF) |-> $past(tick));

    assert_top_off_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_top[g]) && $past(del_code) != DEL_OFF) |-> $past(tick));

    assert_on_after_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_top[g]) |-> !$past(gate_bot[g]) || $past(dly_code) == DLY_OFF);
  end
endmodule

bind pwm_gate_shaper pwm_gate_shaper_chk #(.NPH(NPH), .DLY_W(DLY_W), .DEL_W(DEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in), .dly_code(dly_code),
  .del_code(del_code), .gate_top(gate_top), .gate_bot(gate_bot));

// File: tb/sim_pwm_gate_shaper.sv
`timescale 1ns/1ps
module sim_pwm_gate_shaper;
  localparam int T = 320;
  localparam int NV = 10;
  // {phase[2], level[1], del[7], dly[6], width[8]}
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 1'b1, 7'd127, 6'd63, 8'd5},
    {2'd1, 1'b1, 7'd127, 6'd60, 8'd10},
    {2'd2, 1'b0, 7'd127, 6'd60, 8'd10},
    {2'd0, 1'b1, 7'd124, 6'd63, 8'd2},
    {2'd0, 1'b1, 7'd124, 6'd63, 8'd3},
    {2'd1, 1'b0, 7'd120, 6'd63, 8'd6},
    {2'd1, 1'b0, 7'd120, 6'd63, 8'd7},
    {2'd2, 1'b1, 7'd120, 6'd58, 8'd9},
    {2'd0, 1'b1, 7'd127, 6'd55, 8'd8},
    {2'd2, 1'b1, 7'd64,  6'd0,  8'd100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tick = 1'b1;
  logic [2:0] pwm_in = 3'b000;
  logic [5:0] dly_code = 6'd63;
  logic [6:0] del_code = 7'd127;
  logic [2:0] gate_top, gate_bot;
  int checks = 0, failures = 0;
  bit slow_tick = 1'b0;
  int tdiv = 0;
  int on_cnt, off_cnt, oth_cnt, ovl_cnt;

  always #2.5 clk = ~clk;

  pwm_gate_shaper u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in),
    .dly_code(dly_code), .del_code(del_code), .gate_top(gate_top), .gate_bot(gate_bot));

  always @(negedge clk) begin
    if (slow_tick) begin
      tick <= (tdiv == 3);
      tdiv <= (tdiv + 1) % 4;
    end else begin
      tick <= 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic settle(input logic [2:0] lvl);
    @(negedge clk);
    pwm_in = lvl;
    repeat (400) @(negedge clk);
  endtask

  task automatic run_pulse(input int ph, input logic lvl, input int w);
    pwm_in[ph] = lvl;
    on_cnt = 0; off_cnt = 0; oth_cnt = 0;
    for (int i = 0; i < T; i++) begin
      @(posedge clk);
      @(negedge clk);
      if ((lvl ? gate_top[ph] : gate_bot[ph])) on_cnt++;
      if ((lvl ? gate_bot[ph] : gate_top[ph])) off_cnt++;
      for (int k = 0; k < 3; k++) begin
        if (k != ph && (gate_bot[k] != 1'b1 || gate_top[k] != 1'b0)) oth_cnt++;
        if (gate_top[k] && gate_bot[k]) ovl_cnt++;
      end
      if (i == w - 1) pwm_in[ph] = ~lvl;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ovl_cnt = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset top", int'(gate_top), 0);
    check("R8 reset bot", int'(gate_bot), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 R1 bot after release", int'(gate_bot), 7);

    // R8 with a dead interval of 3 ticks
    dly_code = 6'd60;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 bot held during dead", int'(gate_bot), 0);
    @(negedge clk);
    check("R8 bot after dead", int'(gate_bot), 7);

    // R1 direct follow
    dly_code = 6'd63; del_code = 7'd127;
    settle(3'b000);
    pwm_in = 3'b101;
    @(negedge clk);
    check("R1 top follows", int'(gate_top), 5);
    check("R1 bot complement", int'(gate_bot), 2);

    // table of pulses
    for (int v = 0; v < NV; v++) begin
      int ph, w, m, d, exp_on, exp_off;
      logic lvl;
      ph = int'(VEC[v][23:22]);
      lvl = VEC[v][21];
      del_code = VEC[v][20:14];
      dly_code = VEC[v][13:8];
      w = int'(VEC[v][7:0]);
      m = 127 - int'(del_code);
      d = 63 - int'(dly_code);
      settle(lvl ? 3'b000 : (3'b000 | (3'b001 << ph)));
      run_pulse(ph, lvl, w);
      if (w >= m) begin
        exp_on = (w > d) ? w - d : 0;
        exp_off = T - (w + d);
      end else begin
        exp_on = 0;
        exp_off = T;
      end
      if (lvl) check($sformatf("R2 R5 vec%0d on-time", v), on_cnt, exp_on);
      else     check($sformatf("R6 vec%0d on-time", v), on_cnt, exp_on);
      check($sformatf("R3 vec%0d off-time", v), off_cnt, exp_off);
      check($sformatf("R9 vec%0d other phases", v), oth_cnt, 0);
    end

    // R7: tick every fourth cycle, dead of 3 ticks
    del_code = 7'd127; dly_code = 6'd60;
    slow_tick = 1'b1;
    settle(3'b000);
    run_pulse(0, 1'b1, 40);
    check_range("R7 top with slow tick", on_cnt, 28, 31);
    slow_tick = 1'b0;

    check("R4 overlap cycles", ovl_cnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule